// File: doc/BRIEF.md
# Masked Vector Lane Writeback Unit

This block sits around a packed single-precision divider of up to sixteen 32-bit lanes. It accepts one vector instruction at a time with a valid/ready handshake. The instruction carries its encoding form, two source vectors, the old destination, a per-lane writemask, a merge/zero masking mode, a broadcast bit and a memory-source flag. One cycle after acceptance it presents a registered operand request to the divider. The request holds a dividend and divisor for each lane and the 2-bit rounding mode to use.

Quotients return on a per-lane valid bus. They may arrive in any cycles and in any order. The unit keeps each lane as it arrives. Once every active lane is present, it builds the full 512-bit destination and registers it. Each lane of that destination takes the new quotient, the old value or zero, according to the form, the writemask and the masking mode. Bits above the vector length are then cleared, or kept for the legacy form.

Form encoding on `form_i`: 0 = legacy 128-bit (the destination is also the first source), 1 = plain 128-bit, 2 = plain 256-bit, 3 = masked 128-bit, 4 = masked 256-bit, 5 = masked 512-bit. Lane j is bits [j*32+31 : j*32].

Top module: `vec_lane_wb`

## Requirements
- R1: Forms 0, 1 and 3 have 4 active lanes, forms 2 and 4 have 8, and form 5 has 16. In the operand request, inactive lanes of `dividend_o` and `divisor_o` are zero, and active lanes carry lane j of the first source as the dividend.
- R2: Forms 0 to 2 use no writemask. Every active lane of `dst_o` takes its quotient whatever `wmask_i` holds.
- R3: In forms 3 to 5, an active lane whose `wmask_i` bit is 1 takes its quotient. When that bit is 0, the lane keeps the `old_dst_i` lane if `zero_mode_i`=0, and is 0 if `zero_mode_i`=1.
- R4: `wmask_i` bits at or above the active lane count have no effect on `dst_o`.
- R5: In forms 3 to 5, with `bcast_i`=1 and `mem_src_i`=1, every active divisor lane equals `src2_i[31:0]`. In all other cases, including every form 0 to 2, divisor lane j is lane j of `src2_i`.
- R6: `rnd_o` equals `erc_i` when the form is 5, `bcast_i`=1 and `mem_src_i`=0. Otherwise it equals `csr_rc_i`. Codes: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R7: For forms 1 to 5, every `dst_o` bit from the vector length up to bit 511 is zero.
- R8: For form 0, `dst_o[511:128]` equals `src1_i[511:128]` as captured at acceptance.
- R9: `req_ready_o` is high only when idle. `op_valid_o` rises in the cycle after a request is accepted, and holds with the same operands until `op_ready_i`.
- R10: `dst_valid_o` rises one cycle after the cycle in which the last active lane's quotient is valid. Quotients from earlier cycles are retained. `dst_valid_o` and `dst_o` then hold until `dst_ready_i`, after which the unit is idle again.
- R11: After reset, `req_ready_o`=1, `op_valid_o`=0, `dst_valid_o`=0 and `dst_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Instruction request valid |
| req_ready_o | output | 1 | Unit idle, accepts a request |
| form_i | input | 3 | Encoding form (0 to 5) |
| src1_i | input | 512 | First source (dividends) |
| src2_i | input | 512 | Second source (divisors) |
| old_dst_i | input | 512 | Previous destination value |
| wmask_i | input | 16 | Per-lane writemask |
| zero_mode_i | input | 1 | 1 = zero masked-off lanes, 0 = keep them |
| bcast_i | input | 1 | Broadcast / rounding-control bit |
| mem_src_i | input | 1 | Second source came from memory |
| erc_i | input | 2 | Rounding mode carried in the instruction |
| csr_rc_i | input | 2 | Rounding field of the global control register |
| op_valid_o | output | 1 | Operand request valid |
| op_ready_i | input | 1 | Divider accepts the request |
| dividend_o | output | 512 | Per-lane dividends |
| divisor_o | output | 512 | Per-lane divisors |
| rnd_o | output | 2 | Rounding mode for the divider |
| quo_valid_i | input | 16 | Per-lane quotient valid |
| quo_i | input | 512 | Per-lane quotients |
| dst_valid_o | output | 1 | Destination valid |
| dst_ready_i | input | 1 | Destination consumed |
| dst_o | output | 512 | Merged destination |

## Verification
The assertions assume a few things about the inputs. `form_i` is never 6 or 7 when a request is accepted. `quo_valid_i` is only raised after the operand request has been taken. The divider returns each lane at most once per instruction. The bench drives only the six legal form codes. It raises quotient valids only in the wait phase, either all in one cycle or as even lanes followed by odd lanes. Between those two steps it replaces the even lanes' data with garbage, which exposes any lane that was not retained. It sweeps every form against four writemask patterns, both masking modes, both broadcast values and both source kinds. Each sweep point computes its expected operands, rounding mode and destination arithmetically.

// File: rtl/vlw_pkg.sv
package vlw_pkg;
  typedef enum logic [2:0] {
    FORM_LEGACY_128 = 3'd0,
    FORM_PLAIN_128  = 3'd1,
    FORM_PLAIN_256  = 3'd2,
    FORM_MASKED_128 = 3'd3,
    FORM_MASKED_256 = 3'd4,
    FORM_MASKED_512 = 3'd5
  } form_e;

  function automatic int form_lanes(form_e f);
    case (f)
      FORM_LEGACY_128, FORM_PLAIN_128, FORM_MASKED_128: return 4;
      FORM_PLAIN_256, FORM_MASKED_256:                  return 8;
      default:                                          return 16;
    endcase
  endfunction

  function automatic logic form_masked(form_e f);
    return (f == FORM_MASKED_128) || (f == FORM_MASKED_256) || (f == FORM_MASKED_512);
  endfunction

  function automatic logic form_keeps_upper(form_e f);
    return f == FORM_LEGACY_128;
  endfunction
endpackage

// File: rtl/vlw_operand_sel.sv
module vlw_operand_sel
  import vlw_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 32,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  form_e             form_i,
  input  logic [LANES-1:0]  act_i,
  input  logic [VEC_W-1:0]  src1_i,
  input  logic [VEC_W-1:0]  src2_i,
  input  logic              bcast_i,
  input  logic              mem_src_i,
  input  logic [1:0]        erc_i,
  input  logic [1:0]        csr_rc_i,
  output logic [VEC_W-1:0]  dividend_o,
  output logic [VEC_W-1:0]  divisor_o,
  output logic [1:0]        rnd_o
);
  logic bcast_eff;
  logic use_erc;

  assign bcast_eff = form_masked(form_i) && bcast_i && mem_src_i;
  assign use_erc   = (form_i == FORM_MASKED_512) && bcast_i && !mem_src_i;
  assign rnd_o     = use_erc ? erc_i : csr_rc_i;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] dsr;
    assign dsr = bcast_eff ? src2_i[LANE_W-1:0] : src2_i[j*LANE_W +: LANE_W];
    assign dividend_o[j*LANE_W +: LANE_W] = act_i[j] ? src1_i[j*LANE_W +: LANE_W] : '0;
    assign divisor_o[j*LANE_W +: LANE_W]  = act_i[j] ? dsr : '0;

    // R5
    bcast_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && bcast_eff && act_i[j]) |->
        (divisor_o[j*LANE_W +: LANE_W] == divisor_o[LANE_W-1:0]));

    // R1
    idle_lane_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && !act_i[j]) |->
        (divisor_o[j*LANE_W +: LANE_W] == '0 && dividend_o[j*LANE_W +: LANE_W] == '0));
  end

  // R6
  rnd_global_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && form_i != FORM_MASKED_512) |-> (rnd_o == csr_rc_i));
endmodule

// File: rtl/vlw_lane_merge.sv
module vlw_lane_merge
  import vlw_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 32,
  localparam int VEC_W = LANES * LANE_W
) (
  input  form_e             form_i,
  input  logic [LANES-1:0]  act_i,
  input  logic [LANES-1:0]  wmask_i,
  input  logic              zero_mode_i,
  input  logic [VEC_W-1:0]  quo_i,
  input  logic [VEC_W-1:0]  old_dst_i,
  input  logic [VEC_W-1:0]  src1_i,
  output logic [VEC_W-1:0]  merged_o
);
  logic masked;
  logic keep_upper;

  assign masked     = form_masked(form_i);
  assign keep_upper = form_keeps_upper(form_i);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic take;
    assign take = !masked || wmask_i[j];
    always_comb begin
      if (act_i[j]) begin
        if (take)             merged_o[j*LANE_W +: LANE_W] = quo_i[j*LANE_W +: LANE_W];
        else if (zero_mode_i) merged_o[j*LANE_W +: LANE_W] = '0;
        else                  merged_o[j*LANE_W +: LANE_W] = old_dst_i[j*LANE_W +: LANE_W];
      end else begin
        // legacy form: destination aliases the first source, upper part untouched
        merged_o[j*LANE_W +: LANE_W] = keep_upper ? src1_i[j*LANE_W +: LANE_W] : '0;
      end
    end
  end
endmodule

// File: rtl/vlw_ctrl.sv
module vlw_ctrl #(
  parameter int LANES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  output logic              op_valid_o,
  input  logic              op_ready_i,
  input  logic [LANES-1:0]  quo_valid_i,
  input  logic [LANES-1:0]  act_i,
  output logic              dst_valid_o,
  input  logic              dst_ready_i,
  output logic              accept_o,
  output logic [LANES-1:0]  cap_o,
  output logic              done_o
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;
  state_e            state_q, state_d;
  logic [LANES-1:0]  got_q;

  assign req_ready_o = state_q == S_IDLE;
  assign op_valid_o  = state_q == S_ISSUE;
  assign dst_valid_o = state_q == S_DONE;
  assign accept_o    = req_valid_i && req_ready_o;
  assign cap_o       = (state_q == S_WAIT) ? (quo_valid_i & act_i) : '0;
  assign done_o      = (state_q == S_WAIT) && (&(got_q | cap_o | ~act_i));

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (accept_o)    state_d = S_ISSUE;
      S_ISSUE: if (op_ready_i)  state_d = S_WAIT;
      S_WAIT:  if (done_o)      state_d = S_DONE;
      S_DONE:  if (dst_ready_i) state_d = S_IDLE;
      default:                  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      got_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o) got_q <= '0;
      else          got_q <= got_q | cap_o;
    end
  end

  // R9
  op_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(op_valid_o) |-> $past(req_valid_i && req_ready_o));

  // R9
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_ready_i) |=> op_valid_o);

  // R9
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o || dst_valid_o) |-> !req_ready_o);
endmodule

// File: rtl/vec_lane_wb.sv
module vec_lane_wb
  import vlw_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 32,
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        form_i,
  input  logic [VEC_W-1:0]  src1_i,
  input  logic [VEC_W-1:0]  src2_i,
  input  logic [VEC_W-1:0]  old_dst_i,
  input  logic [LANES-1:0]  wmask_i,
  input  logic              zero_mode_i,
  input  logic              bcast_i,
  input  logic              mem_src_i,
  input  logic [1:0]        erc_i,
  input  logic [1:0]        csr_rc_i,
  output logic              op_valid_o,
  input  logic              op_ready_i,
  output logic [VEC_W-1:0]  dividend_o,
  output logic [VEC_W-1:0]  divisor_o,
  output logic [1:0]        rnd_o,
  input  logic [LANES-1:0]  quo_valid_i,
  input  logic [VEC_W-1:0]  quo_i,
  output logic              dst_valid_o,
  input  logic              dst_ready_i,
  output logic [VEC_W-1:0]  dst_o
);
  form_e             form_q;
  logic [VEC_W-1:0]  src1_q, src2_q, old_q, quo_q, dst_q, eff_quo, merged;
  logic [LANES-1:0]  wmask_q, act, cap;
  logic              zero_mode_q, bcast_q, mem_src_q, accept, done;
  logic [1:0]        erc_q, csr_rc_q;

  for (genvar j = 0; j < LANES; j++) begin : g_act
    assign act[j] = j < form_lanes(form_q);
    assign eff_quo[j*LANE_W +: LANE_W] = cap[j] ? quo_i[j*LANE_W +: LANE_W]
                                                : quo_q[j*LANE_W +: LANE_W];
  end

  vlw_ctrl #(.LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .op_valid_o, .op_ready_i,
    .quo_valid_i, .act_i(act), .dst_valid_o, .dst_ready_i,
    .accept_o(accept), .cap_o(cap), .done_o(done)
  );

  vlw_operand_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_opsel (
    .clk_i, .rst_ni, .op_valid_i(op_valid_o), .form_i(form_q), .act_i(act),
    .src1_i(src1_q), .src2_i(src2_q), .bcast_i(bcast_q), .mem_src_i(mem_src_q),
    .erc_i(erc_q), .csr_rc_i(csr_rc_q),
    .dividend_o, .divisor_o, .rnd_o
  );

  vlw_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .form_i(form_q), .act_i(act), .wmask_i(wmask_q), .zero_mode_i(zero_mode_q),
    .quo_i(eff_quo), .old_dst_i(old_q), .src1_i(src1_q), .merged_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      form_q      <= FORM_LEGACY_128;
      src1_q      <= '0;
      src2_q      <= '0;
      old_q       <= '0;
      wmask_q     <= '0;
      zero_mode_q <= 1'b0;
      bcast_q     <= 1'b0;
      mem_src_q   <= 1'b0;
      erc_q       <= '0;
      csr_rc_q    <= '0;
    end else if (accept) begin
      form_q      <= form_e'(form_i);
      src1_q      <= src1_i;
      src2_q      <= src2_i;
      old_q       <= old_dst_i;
      wmask_q     <= wmask_i;
      zero_mode_q <= zero_mode_i;
      bcast_q     <= bcast_i;
      mem_src_q   <= mem_src_i;
      erc_q       <= erc_i;
      csr_rc_q    <= csr_rc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      dst_q <= '0;
    end else begin
      quo_q <= eff_quo;
      if (done) dst_q <= merged;
    end
  end

  assign dst_o = dst_q;

  // R10
  dst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_o && !dst_ready_i) |=> (dst_valid_o && $stable(dst_o)));

  if (LANES > 4) begin : g_upper_chk
    // R7
    upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dst_valid_o && form_lanes(form_q) == 4 && !form_keeps_upper(form_q)) |->
        (dst_o[VEC_W-1:4*LANE_W] == '0));
    // R8
    legacy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dst_valid_o && form_keeps_upper(form_q)) |->
        (dst_o[VEC_W-1:4*LANE_W] == src1_q[VEC_W-1:4*LANE_W]));
  end
endmodule

// File: tb/sim_vec_lane_wb.sv
`timescale 1ns/1ps
module sim_vec_lane_wb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, op_ready = 1'b0, dst_ready = 1'b0;
  logic [2:0]   form = '0;
  logic [511:0] src1 = '0, src2 = '0, old_dst = '0, quo = '0;
  logic [15:0]  wmask = '0, quo_valid = '0;
  logic         zero_mode = 1'b0, bcast = 1'b0, mem_src = 1'b0;
  logic [1:0]   erc = '0, csr_rc = '0;
  logic         req_ready, op_valid, dst_valid;
  logic [511:0] dividend, divisor, dst;
  logic [1:0]   rnd;
  int           errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  vec_lane_wb u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .form_i(form), .src1_i(src1), .src2_i(src2), .old_dst_i(old_dst), .wmask_i(wmask),
    .zero_mode_i(zero_mode), .bcast_i(bcast), .mem_src_i(mem_src), .erc_i(erc),
    .csr_rc_i(csr_rc), .op_valid_o(op_valid), .op_ready_i(op_ready),
    .dividend_o(dividend), .divisor_o(divisor), .rnd_o(rnd), .quo_valid_i(quo_valid),
    .quo_i(quo), .dst_valid_o(dst_valid), .dst_ready_i(dst_ready), .dst_o(dst)
  );

  task automatic chk(string req, logic [511:0] got, logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] pat(int s, int j, int k);
    return 32'(s * 32'h9E3779B1 + j * 32'h01000193 + k * 32'h5BD1E995 + 1);
  endfunction

  function automatic int nlanes(int f);
    return (f == 2 || f == 4) ? 8 : (f == 5) ? 16 : 4;
  endfunction

  task automatic run_txn(int f, logic [15:0] wm, logic zm, logic bc, logic mem, int seed);
    logic [511:0] e_dvd, e_dsr, e_dst, q_all;
    logic [1:0]   e_rnd;
    int n;
    bit masked, legacy, bce, split;
    n = nlanes(f);
    masked = f >= 3;
    legacy = f == 0;
    bce = masked && bc && mem;
    split = seed[0];
    @(negedge clk);
    form = 3'(f); wmask = wm; zero_mode = zm; bcast = bc; mem_src = mem;
    erc = 2'(seed); csr_rc = ~2'(seed);
    for (int j = 0; j < 16; j++) begin
      src1[j*32 +: 32]    = pat(seed, j, 1);
      src2[j*32 +: 32]    = pat(seed, j, 2);
      old_dst[j*32 +: 32] = pat(seed, j, 3);
      q_all[j*32 +: 32]   = pat(seed, j, 4);
    end
    for (int j = 0; j < 16; j++) begin
      if (j < n) begin
        e_dvd[j*32 +: 32] = src1[j*32 +: 32];
        e_dsr[j*32 +: 32] = bce ? src2[31:0] : src2[j*32 +: 32];
        if (!masked || wm[j]) e_dst[j*32 +: 32] = q_all[j*32 +: 32];
        else if (zm)          e_dst[j*32 +: 32] = '0;
        else                  e_dst[j*32 +: 32] = old_dst[j*32 +: 32];
      end else begin
        e_dvd[j*32 +: 32] = '0;
        e_dsr[j*32 +: 32] = '0;
        e_dst[j*32 +: 32] = legacy ? src1[j*32 +: 32] : '0;
      end
    end
    e_rnd = (f == 5 && bc && !mem) ? erc : csr_rc;
    req_valid = 1'b1;
    chk("R9 req_ready idle", 512'(req_ready), 512'(1));
    @(negedge clk);
    req_valid = 1'b0;
    src1 = ~src1; src2 = ~src2; old_dst = ~old_dst; // inputs change after accept
    chk("R9 op_valid after accept", 512'(op_valid), 512'(1));
    chk("R9 req_ready busy", 512'(req_ready), 512'(0));
    chk("R1 dividend", dividend, e_dvd);
    chk("R5 divisor", divisor, e_dsr);
    chk("R6 rnd", 512'(rnd), 512'(e_rnd));
    @(negedge clk);
    chk("R9 op_valid hold", 512'(op_valid), 512'(1));
    chk("R9 divisor hold", divisor, e_dsr);
    op_ready = 1'b1;
    @(negedge clk);
    op_ready = 1'b0;
    chk("R9 op_valid drop", 512'(op_valid), 512'(0));
    if (split) begin
      for (int j = 0; j < 16; j++) quo_valid[j] = (j % 2 == 0);
      quo = q_all;
      @(negedge clk);
      chk("R10 no early dst", 512'(dst_valid), 512'(0));
      for (int j = 0; j < 16; j++) quo_valid[j] = (j % 2 == 1);
      quo = ~q_all;
      for (int j = 1; j < 16; j += 2) quo[j*32 +: 32] = q_all[j*32 +: 32];
    end else begin
      quo_valid = '1;
      quo = q_all;
    end
    @(negedge clk);
    quo_valid = '0; quo = '0;
    chk("R10 dst_valid", 512'(dst_valid), 512'(1));
    chk(masked ? "R3 R4 R7 dst" : (legacy ? "R2 R8 dst" : "R2 R7 dst"), dst, e_dst);
    @(negedge clk);
    chk("R10 dst hold", dst, e_dst);
    dst_ready = 1'b1;
    @(negedge clk);
    dst_ready = 1'b0;
    chk("R10 release", 512'({dst_valid, req_ready}), 512'(2'b01));
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] masks [4];
    int seed;
    masks[0] = 16'hFFFF; masks[1] = 16'h0000; masks[2] = 16'hA5C3; masks[3] = 16'hFFF0;
    seed = 7;
    repeat (3) @(negedge clk);
    // R11
    chk("R11 reset", {dst, 3'(0), req_ready, op_valid, dst_valid}, {512'(0), 6'b000100});
    rst_n = 1'b1;
    for (int f = 0; f < 6; f++)
      for (int m = 0; m < 4; m++)
        for (int b = 0; b < 8; b++) begin
          run_txn(f, masks[m], b[0], b[1], b[2], seed);
          seed += 13;
        end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule